// File: doc/BRIEF.md
# Serial Control and Status Port for an Eight-Channel Low-Side Driver

This block is the serial slave that sits in front of an eight-channel switch driver. A host lowers chip select and clocks a frame. On each falling SCK edge a control bit is shifted in from SDI. On each rising SCK edge a status bit is shifted out on SDO. The status word is sampled from the channel status inputs when chip select falls. The first status bit is valid on SDO before the first clock.

The received control word is copied to the channel output latch when chip select rises. This happens only when the number of SCK cycles in the frame is a nonzero multiple of the word width. Any other frame leaves the latch untouched. Several bytes may be clocked in one frame, and the last byte wins.

The word is packed with the even channels in the upper half and the odd channels in the lower half. The same packing is used in both directions.

The SPI pins are sampled by a fast system clock through two-flop synchronisers. SCK must run at no more than a quarter of the system clock, and chip select may change only while SCK is low. An active-low external reset and an undervoltage flag are ORed into one internal reset, which turns every channel off.

Top module: `octl_spi_ctrl`

## Requirements
- R1: While selected, the block samples SDI on every falling SCK edge into a shift register, first bit in ending as the MSB. After a committed frame, the latch holds the last N bits that were clocked in.
- R2: When chip select falls, the block captures the status inputs. SDO carries word bit N-1 before the first SCK edge, and word bit N-1-k after the k-th falling SCK edge, updated on the next rising edge.
- R3: `spi_sdo_oe` is 1 while the block is selected and 0 while chip select is high.
- R4: When chip select rises, the shift register is copied to the latch only if the SCK cycle count is a nonzero multiple of N. Otherwise `ctl_out` does not change.
- R5: The SCK cycle counter stops at 2^CNT_W-1 instead of wrapping. A frame longer than that is rejected, even if its length is a multiple of N, for example 264 cycles.
- R6: For N=8, word bits 7 down to 0 belong to channels 2, 4, 6, 8, 1, 3, 5, 7. `ctl_out[c-1]` and `stat_in[c-1]` belong to channel c. For example, a received word of 0x80 turns on only channel 2, which is `ctl_out` = 0x02.
- R7: While `ext_rst_n` is 0 or `uv_flag` is 1, `ctl_out` is 0 and SDO is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| uv_flag | input | 1 | Undervoltage flag, active high, acts as a reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial control data in |
| spi_sdo | output | 1 | Serial status data out |
| spi_sdo_oe | output | 1 | SDO output enable; the pad is high-impedance when this is 0 |
| stat_in | input | N | Per-channel status, bit c-1 for channel c |
| ctl_out | output | N | Per-channel on/off control, bit c-1 for channel c |

## Verification
The bench builds the block with its defaults: N=8 and CNT_W=8. With these values the counter saturates at 255, so a 264-cycle frame reaches the saturation rule in about two thousand system clocks. That frame would be accepted if the counter wrapped, which is what makes it a useful test. The same N lets the bench restate the channel packing as a closed-form position for each channel. The bench also covers zero-length, short, odd-length and multi-byte frames at an SCK of one eighth of the system clock.

// File: rtl/octl_pkg.sv
package octl_pkg;

  // Position of channel (ch_idx+1) inside a word of n bits:
  // even channels fill the upper half, odd channels the lower half.
  function automatic int lane_pos(input int ch_idx, input int n);
    if (ch_idx % 2 == 1) return n - 1 - (ch_idx - 1) / 2;
    else                 return n / 2 - 1 - ch_idx / 2;
  endfunction

  // A frame is taken when its clock count is a nonzero multiple of n.
  function automatic bit frame_len_ok(input int cnt, input int n);
    return (cnt != 0) && ((cnt % n) == 0);
  endfunction

endpackage

// File: rtl/octl_sync.sv
module octl_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_lvl,
  output logic [W-1:0] q_rise,
  output logic [W-1:0] q_fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= d_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q_lvl[i]  = s2;
    assign q_rise[i] = s2 & ~s3;
    assign q_fall[i] = ~s2 & s3;
  end
endmodule

// File: rtl/octl_lane_map.sv
module octl_lane_map #(
  parameter int N       = 8,
  parameter bit TO_WORD = 1'b1
) (
  input  logic [N-1:0] a,
  output logic [N-1:0] y
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam int P = octl_pkg::lane_pos(i, N);
    if (TO_WORD) begin : g_pack
      assign y[P] = a[i];
    end else begin : g_unpack
      assign y[i] = a[P];
    end
  end
endmodule

// File: rtl/octl_frame.sv
module octl_frame #(
  parameter int N     = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             sdi_lvl,
  input  logic [N-1:0]     stat_word,
  output logic             sel,
  output logic             sdo,
  output logic [N-1:0]     sreg,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sel  <= 1'b0;
      sdo  <= 1'b0;
      sreg <= '0;
      cnt  <= '0;
    end else if (cs_fall) begin
      sel  <= 1'b1;
      cnt  <= '0;
      sreg <= stat_word;
      sdo  <= stat_word[N-1];
    end else if (cs_rise) begin
      sel <= 1'b0;
    end else if (sel) begin
      if (sck_fall) begin
        sreg <= {sreg[N-2:0], sdi_lvl};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (sck_rise) sdo <= sreg[N-1];
    end
  end

  assign frame_ok = octl_pkg::frame_len_ok(int'(cnt), N);
endmodule

// File: rtl/octl_commit.sv
module octl_commit #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [N-1:0] word_in,
  output logic [N-1:0] word_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)       word_q <= '0;
    else if (take) word_q <= word_in;
  end
endmodule

// File: rtl/octl_spi_ctrl.sv
module octl_spi_ctrl #(
  parameter int N     = 8,
  parameter int CNT_W = 8
) (
  input  logic         clk,
  input  logic         ext_rst_n,
  input  logic         uv_flag,
  input  logic         spi_sck,
  input  logic         spi_cs_n,
  input  logic         spi_sdi,
  output logic         spi_sdo,
  output logic         spi_sdo_oe,
  input  logic [N-1:0] stat_in,
  output logic [N-1:0] ctl_out
);
  localparam int PINS = 3;
  localparam logic [PINS-1:0] PIN_IDLE = 3'b010; // {sdi, cs_n, sck}

  logic             rst_i;
  logic [PINS-1:0]  pin_lvl, pin_rise, pin_fall;
  logic             sck_rise_ev, sck_fall_ev, cs_rise_ev, cs_fall_ev;
  logic             sel_w, frame_ok_w, take_w;
  logic [N-1:0]     stat_word_w, sreg_w, ctl_word_w;
  logic [CNT_W-1:0] cnt_w;

  assign rst_i = ~ext_rst_n | uv_flag;

  octl_sync #(.W(PINS), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst_i),
    .d_in({spi_sdi, spi_cs_n, spi_sck}),
    .q_lvl(pin_lvl), .q_rise(pin_rise), .q_fall(pin_fall)
  );

  assign sck_rise_ev = pin_rise[0];
  assign sck_fall_ev = pin_fall[0];
  assign cs_rise_ev  = pin_rise[1];
  assign cs_fall_ev  = pin_fall[1];

  octl_lane_map #(.N(N), .TO_WORD(1'b1)) u_pack (
    .a(stat_in), .y(stat_word_w)
  );

  octl_frame #(.N(N), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst(rst_i),
    .cs_fall(cs_fall_ev), .cs_rise(cs_rise_ev),
    .sck_rise(sck_rise_ev), .sck_fall(sck_fall_ev),
    .sdi_lvl(pin_lvl[2]), .stat_word(stat_word_w),
    .sel(sel_w), .sdo(spi_sdo), .sreg(sreg_w),
    .cnt(cnt_w), .frame_ok(frame_ok_w)
  );

  assign take_w = cs_rise_ev & frame_ok_w;

  octl_commit #(.N(N)) u_commit (
    .clk(clk), .rst(rst_i), .take(take_w),
    .word_in(sreg_w), .word_q(ctl_word_w)
  );

  octl_lane_map #(.N(N), .TO_WORD(1'b0)) u_unpack (
    .a(ctl_word_w), .y(ctl_out)
  );

  assign spi_sdo_oe = sel_w;
endmodule

// File: rtl/octl_spi_ctrl_chk.sv
module octl_spi_ctrl_chk #(
  parameter int N     = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_i,
  input logic             cs_rise_ev,
  input logic             cs_fall_ev,
  input logic             sck_fall_ev,
  input logic             sel_w,
  input logic             frame_ok_w,
  input logic [N-1:0]     sreg_w,
  input logic [N-1:0]     ctl_word_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic [N-1:0]     stat_in,
  input logic [N-1:0]     ctl_out,
  input logic             spi_sdo,
  input logic             spi_sdo_oe
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst_i)
    (cs_rise_ev && !frame_ok_w) |=> $stable(ctl_out)); // R4

  AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (rst_i)
    (cs_rise_ev && frame_ok_w) |=> (ctl_word_w == $past(sreg_w))); // R1

  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (rst_i)
    !cs_rise_ev |=> $stable(ctl_word_w)); // R4

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst_i)
    (sel_w && sck_fall_ev && !cs_fall_ev && cnt_w == CNT_TOP) |=> (cnt_w == CNT_TOP)); // R5

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst_i)
    cs_rise_ev |=> !spi_sdo_oe); // R3

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (rst_i)
    cs_fall_ev |=> (spi_sdo_oe && spi_sdo == $past(stat_in[1]))); // R6

  always @(posedge clk) begin
    if (rst_i) begin
      AST_RESET_OFF: assert (ctl_out == '0 && !spi_sdo_oe); // R7
    end
  end
endmodule

bind octl_spi_ctrl octl_spi_ctrl_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_i(rst_i),
  .cs_rise_ev(cs_rise_ev), .cs_fall_ev(cs_fall_ev), .sck_fall_ev(sck_fall_ev),
  .sel_w(sel_w), .frame_ok_w(frame_ok_w), .sreg_w(sreg_w),
  .ctl_word_w(ctl_word_w), .cnt_w(cnt_w),
  .stat_in(stat_in), .ctl_out(ctl_out),
  .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe)
);

// File: tb/sim_octl_spi_ctrl.sv
module sim_octl_spi_ctrl;
  localparam int N = 8;
  localparam int CNT_W = 8;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0, uv_flag = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_sdi = 1'b0;
  logic spi_sdo, spi_sdo_oe;
  logic [N-1:0] stat_in = '0, ctl_out;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] model_ctl = '0;

  always #10 clk = ~clk;

  octl_spi_ctrl #(.N(N), .CNT_W(CNT_W)) u0 (
    .clk(clk), .ext_rst_n(ext_rst_n), .uv_flag(uv_flag),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .stat_in(stat_in), .ctl_out(ctl_out)
  );

  // Word bit position of channel c (1-based), written independently of the RTL.
  function automatic int bpos(input int c);
    if (c % 2 == 0) return N - c / 2;
    return N / 2 - (c + 1) / 2;
  endfunction

  function automatic logic [N-1:0] to_word(input logic [N-1:0] chv);
    logic [N-1:0] w = '0;
    for (int c = 1; c <= N; c++) w[bpos(c)] = chv[c-1];
    return w;
  endfunction

  function automatic logic [N-1:0] to_ch(input logic [N-1:0] w);
    logic [N-1:0] v = '0;
    for (int c = 1; c <= N; c++) v[c-1] = w[bpos(c)];
    return v;
  endfunction

  function automatic bit accept(input int nb);
    int top = (1 << CNT_W) - 1;
    int eff = (nb > top) ? top : nb;
    return (eff > 0) && (eff % N == 0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int nb, input logic [N-1:0] stat,
                           input logic [N-1:0] payload, input string tag);
    logic [N-1:0] sw = to_word(stat);
    @(negedge clk);
    stat_in  = stat;
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 enabled while selected", {31'd0, spi_sdo_oe}, 32'd1);
    chk("R2 first status bit", {31'd0, spi_sdo}, {31'd0, sw[N-1]});
    for (int i = 0; i < nb; i++) begin
      spi_sck = 1'b1;
      spi_sdi = (i >= nb - N) ? payload[nb-1-i] : 1'($urandom % 2);
      repeat (HALF) @(negedge clk);
      if (i < N && i > 0) chk("R2 status bit", {31'd0, spi_sdo}, {31'd0, sw[N-1-i]});
      spi_sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 disabled after deselect", {31'd0, spi_sdo_oe}, 32'd0);
    if (accept(nb)) model_ctl = to_ch(payload);
    chk(tag, {24'd0, ctl_out}, {24'd0, model_ctl});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    repeat (5) @(negedge clk);
    chk("R7 reset clears latch", {24'd0, ctl_out}, 32'd0);
    chk("R7 reset disables sdo", {31'd0, spi_sdo_oe}, 32'd0);
    ext_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_frame(8, 8'h3C, 8'hA5, "R1 R6 single byte commit");
    run_frame(8, 8'hC3, 8'h80, "R6 msb is channel 2");
    chk("R6 msb lands on channel 2", {24'd0, ctl_out}, 32'h02);
    run_frame(8, 8'h01, 8'h01, "R6 lsb is channel 7");
    chk("R6 lsb lands on channel 7", {24'd0, ctl_out}, 32'h40);
    run_frame(7, 8'h55, 8'h7F, "R4 seven clocks rejected");
    run_frame(0, 8'hAA, 8'h00, "R4 empty frame rejected");
    run_frame(9, 8'h0F, 8'h00, "R4 nine clocks rejected");
    run_frame(16, 8'hF0, 8'h5A, "R1 R4 two bytes last wins");
    run_frame(264, 8'h11, 8'hFF, "R5 saturated frame rejected");
    run_frame(256, 8'h22, 8'h00, "R5 256 clocks rejected");
    run_frame(24, 8'h99, 8'hE7, "R4 three bytes commit");

    @(negedge clk);
    uv_flag = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 undervoltage clears latch", {24'd0, ctl_out}, 32'd0);
    uv_flag = 1'b0;
    model_ctl = '0;
    repeat (4) @(negedge clk);
    run_frame(8, 8'h00, 8'h3C, "R1 commit after undervoltage");
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 external reset clears latch", {24'd0, ctl_out}, 32'd0);
    ext_rst_n = 1'b1;
    model_ctl = '0;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 30; k++) begin
      int nb = (k % 3 == 0) ? 8 * (1 + int'($urandom % 3)) : int'($urandom % 20);
      run_frame(nb, N'($urandom), N'($urandom), "R4 random frame");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule